// File: doc/BRIEF.md
# RV64 Register-Register Execute Unit

This unit executes one integer instruction of a small 64-bit RISC-V subset. It takes a 32-bit instruction word and two 64-bit operand values, which a register file reads at the source indices the unit exposes. It returns a 64-bit result, a write strobe and the destination index. The supported group is the register-register set: add, sub, low-half mul, sll, srl, sra, and, or and xor. The unit also executes addi, whose 12-bit immediate is sign-extended to 64 bits. Every other encoding raises an illegal flag and suppresses the write.

Decoding, the arithmetic and the shifts are combinational. A parameter chooses whether result, write strobe, destination and illegal flag leave through an output register, which is the default, or leave combinationally. The source indices always come straight from the instruction word, so a register file can be read in the same cycle. Register file storage, memory, loads, branches and program-counter handling belong to the surrounding core.

Top module: `rrx_exec_unit`

## Requirements
- R1: `rs1_idx_o` equals instruction bits 19:15 and `rs2_idx_o` equals bits 24:20 combinationally; `dest_o` carries bits 11:7 of the instruction it belongs to.
- R2: With opcode bits 6:0 = 0110011 and funct3 (bits 14:12) = 000, funct7 (bits 31:25) = 0000000 gives `src_a_i + src_b_i` and 0100000 gives `src_a_i - src_b_i`, both modulo 2^64.
- R3: With opcode 0110011, funct3 000 and funct7 0000001, the result is the low 64 bits of the unsigned product of the operands.
- R4: With opcode 0110011, funct7 0000000 and funct3 001 the unit computes a left shift, with funct3 101 a logical right shift, and with funct7 0100000 and funct3 101 an arithmetic right shift that replicates bit 63. The shift amount is `src_b_i[5:0]`, and bits 63:6 of `src_b_i` have no effect.
- R5: With opcode 0110011 and funct7 0000000, funct3 111 gives AND, 110 gives OR and 100 gives XOR of the operands.
- R6: With opcode 0010011 and funct3 000, the result is `src_a_i` plus instruction bits 31:20 sign-extended from bit 31 to 64 bits, and `src_b_i` and bits 24:20 as a value have no effect.
- R7: `wr_en_o` is 0 whenever the destination field is 0. The result is still produced.
- R8: Any other combination of opcode, funct3 and funct7 drives `illegal_o` to 1, `wr_en_o` to 0 and `result_o` to 0. A supported encoding drives `illegal_o` to 0.
- R9: With `OUT_REG`=1, the outputs reflect the inputs present at the previous rising clock edge, and a synchronous active-high `rst` clears result, write strobe, destination and illegal flag to 0.
- R10: The word 0x00B50533 executes as add, with destination 10, rs1 index 10 and rs2 index 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | XLEN | Value of the first source register |
| src_b_i | input | XLEN | Value of the second source register |
| rs1_idx_o | output | 5 | First source index (combinational) |
| rs2_idx_o | output | 5 | Second source index (combinational) |
| result_o | output | XLEN | Computed result |
| wr_en_o | output | 1 | Destination write strobe |
| dest_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Unsupported encoding flag |

## Verification
The source indices are combinational, so the bench checks them 1 ns after it drives a word at the falling clock edge. Result, write strobe, destination and illegal flag come from the output register and are due one rising edge later. The bench checks them at the following falling edge, before it drives the next word. Each vector therefore occupies exactly one clock cycle, and no check samples at a rising edge. The reset checks sample at a falling edge after a rising edge at which reset was high.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [6:0] F7_MULD = 7'b0000001;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_MUL,
    OP_SLL,
    OP_SRL,
    OP_SRA,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_ADDI
  } rrx_op_e;

  // Packed most-significant first: matches the instruction bit layout.
  typedef struct packed {
    logic [6:0] funct7;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [2:0] funct3;
    logic [4:0] rd;
    logic [6:0] opcode;
  } rrx_fields_t;

endpackage

// File: rtl/rrx_decoder.sv
module rrx_decoder
  import rrx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr,
  output rrx_fields_t     flds,
  output rrx_op_e         op,
  output logic            illegal,
  output logic [XLEN-1:0] imm
);

  localparam int IMMW = 12;

  assign flds = rrx_fields_t'(instr);

  // Sign-extended immediate from the top twelve bits.
  assign imm = {{(XLEN-IMMW){instr[31]}}, instr[31:20]};

  always_comb begin
    op = OP_NONE;
    if (flds.opcode == OPC_REG) begin
      case ({flds.funct7, flds.funct3})
        {F7_BASE, 3'b000}: op = OP_ADD;
        {F7_ALT,  3'b000}: op = OP_SUB;
        {F7_MULD, 3'b000}: op = OP_MUL;
        {F7_BASE, 3'b001}: op = OP_SLL;
        {F7_BASE, 3'b101}: op = OP_SRL;
        {F7_ALT,  3'b101}: op = OP_SRA;
        {F7_BASE, 3'b111}: op = OP_AND;
        {F7_BASE, 3'b110}: op = OP_OR;
        {F7_BASE, 3'b100}: op = OP_XOR;
        default:           op = OP_NONE;
      endcase
    end else if (flds.opcode == OPC_IMM) begin
      if (flds.funct3 == 3'b000) op = OP_ADDI;
    end
  end

  assign illegal = (op == OP_NONE);

endmodule

// File: rtl/rrx_shifter.sv
module rrx_shifter #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);

  // One right-shifting barrel serves all three shifts: a left shift
  // reverses the bits on entry and on exit.
  logic [XLEN-1:0] rev_in;
  logic [XLEN-1:0] rev_out;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = din[XLEN-1-i];
    assign rev_out[i] = stg[SHW][XLEN-1-i];
  end

  assign fill   = arith & ~left & din[XLEN-1];
  assign stg[0] = left ? rev_in : din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
  end

  assign dout = left ? rev_out : stg[SHW];

endmodule

// File: rtl/rrx_alu.sv
module rrx_alu
  import rrx_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  rrx_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] res
);

  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] prod;

  rrx_shifter #(.XLEN(XLEN)) u_shift (
    .din   (a),
    .amt   (b[SHW-1:0]),
    .left  (op == OP_SLL),
    .arith (op == OP_SRA),
    .dout  (sh_res)
  );

  // Product truncated to the low XLEN bits.
  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = prod;
      OP_SLL,
      OP_SRL,
      OP_SRA:  res = sh_res;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ADDI: res = a + imm;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/rrx_outreg.sv
module rrx_outreg #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] res_d,
  input  logic            we_d,
  input  logic [4:0]      dest_d,
  input  logic            ill_d,
  output logic [XLEN-1:0] res_q,
  output logic            we_q,
  output logic [4:0]      dest_q,
  output logic            ill_q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_q  <= '0;
        we_q   <= 1'b0;
        dest_q <= '0;
        ill_q  <= 1'b0;
      end else begin
        res_q  <= res_d;
        we_q   <= we_d;
        dest_q <= dest_d;
        ill_q  <= ill_d;
      end
    end
  end else begin : g_comb
    wire unused_clkrst = clk | rst;
    assign res_q  = res_d;
    assign we_q   = we_d;
    assign dest_q = dest_d;
    assign ill_q  = ill_d;
  end

endmodule

// File: rtl/rrx_exec_unit.sv
module rrx_exec_unit
  import rrx_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [4:0]      rs1_idx_o,
  output logic [4:0]      rs2_idx_o,
  output logic [XLEN-1:0] result_o,
  output logic            wr_en_o,
  output logic [4:0]      dest_o,
  output logic            illegal_o
);

  rrx_fields_t     flds;
  rrx_op_e         op;
  logic            ill;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] res_c;
  logic            we_c;

  rrx_decoder #(.XLEN(XLEN)) u_dec (
    .instr   (instr_i),
    .flds    (flds),
    .op      (op),
    .illegal (ill),
    .imm     (imm)
  );

  rrx_alu #(.XLEN(XLEN)) u_alu (
    .op  (op),
    .a   (src_a_i),
    .b   (src_b_i),
    .imm (imm),
    .res (alu_res)
  );

  // Unsupported encodings never write and present a zero result;
  // the zero register is never a write target.
  assign res_c = ill ? '0 : alu_res;
  assign we_c  = ~ill & (flds.rd != 5'd0);

  assign rs1_idx_o = flds.rs1;
  assign rs2_idx_o = flds.rs2;

  rrx_outreg #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst    (rst),
    .res_d  (res_c),
    .we_d   (we_c),
    .dest_d (flds.rd),
    .ill_d  (ill),
    .res_q  (result_o),
    .we_q   (wr_en_o),
    .dest_q (dest_o),
    .ill_q  (illegal_o)
  );

endmodule

// File: rtl/rrx_exec_unit_chk.sv
module rrx_exec_unit_chk #(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] src_a_i,
  input logic [XLEN-1:0] src_b_i,
  input logic [XLEN-1:0] result_o,
  input logic            wr_en_o,
  input logic [4:0]      dest_o,
  input logic            illegal_o
);

  AST_X0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> dest_o != 5'd0);                                      // R7

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr_en_o);                                          // R8

  AST_ILLEGAL_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> result_o == '0);                                    // R8

  if (OUT_REG) begin : g_seq
    AST_RESET_CLEARS: assert property (@(posedge clk)
      $past(rst) |-> (!wr_en_o && !illegal_o && result_o == '0));     // R9

    AST_DEST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> dest_o == $past(instr_i[11:7]));                       // R9

    AST_ADD_WRAPS: assert property (@(posedge clk) disable iff (rst)
      (instr_i[6:0] == 7'b0110011 && instr_i[14:12] == 3'b000 &&
       instr_i[31:25] == 7'b0000000)
      |=> result_o == $past(src_a_i + src_b_i));                      // R2
  end

endmodule

bind rrx_exec_unit rrx_exec_unit_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_i   (instr_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .result_o  (result_o),
  .wr_en_o   (wr_en_o),
  .dest_o    (dest_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_rrx_exec_unit.sv
`timescale 1ns/1ps
module tb_rrx_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic [63:0] sa = 64'h0, sb = 64'h0;
  logic [4:0]  rs1_idx, rs2_idx, dest;
  logic [63:0] result;
  logic        wr_en, illegal;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  rrx_exec_unit dut (
    .clk(clk), .rst(rst), .instr_i(instr), .src_a_i(sa), .src_b_i(sb),
    .rs1_idx_o(rs1_idx), .rs2_idx_o(rs2_idx), .result_o(result),
    .wr_en_o(wr_en), .dest_o(dest), .illegal_o(illegal)
  );

  function automatic logic [31:0] rt(logic [6:0] f7, logic [2:0] f3,
                                     logic [4:0] rd, logic [4:0] r1, logic [4:0] r2);
    return {f7, r2, r1, f3, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] it(logic [11:0] im, logic [2:0] f3,
                                     logic [4:0] rd, logic [4:0] r1);
    return {im, r1, f3, rd, 7'b0010011};
  endfunction

  task automatic rnd(output logic [63:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    v = seed;
  endtask

  // Expected behaviour straight from the requirement list.
  task automatic model(input logic [31:0] iw, input logic [63:0] a, b,
                       output logic [63:0] r, output logic lg);
    logic [5:0] sh;
    logic [63:0] ex;
    sh = b[5:0];
    ex = {{52{iw[31]}}, iw[31:20]};
    lg = 1'b1;
    r  = 64'h0;
    if (iw[6:0] == 7'b0110011) begin
      case ({iw[31:25], iw[14:12]})
        {7'h00, 3'd0}: r = a + b;
        {7'h20, 3'd0}: r = a - b;
        {7'h01, 3'd0}: r = a * b;
        {7'h00, 3'd1}: r = a << sh;
        {7'h00, 3'd5}: r = a >> sh;
        {7'h20, 3'd5}: r = 64'($signed(a) >>> sh);
        {7'h00, 3'd7}: r = a & b;
        {7'h00, 3'd6}: r = a | b;
        {7'h00, 3'd4}: r = a ^ b;
        default:       lg = 1'b0;
      endcase
    end else if (iw[6:0] == 7'b0010011 && iw[14:12] == 3'd0) begin
      r = a + ex;
    end else begin
      lg = 1'b0;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic vec(input logic [31:0] iw, input logic [63:0] a, b, input string req);
    logic [63:0] er;
    logic lg;
    model(iw, a, b, er, lg);
    instr = iw; sa = a; sb = b;
    #1;
    chk("R1 rs1", 64'(rs1_idx), 64'(iw[19:15]));
    chk("R1 rs2", 64'(rs2_idx), 64'(iw[24:20]));
    @(negedge clk);
    chk(req, result, lg ? er : 64'h0);
    chk({req, " we"}, 64'(wr_en), 64'(lg && iw[11:7] != 5'd0));
    chk({req, " ill"}, 64'(illegal), 64'(!lg));
    chk("R1 dest", 64'(dest), 64'(iw[11:7]));
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, u;
    instr = rt(7'h00, 3'd0, 5'd7, 5'd1, 5'd2);
    sa = 64'h1234; sb = 64'h1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 rst res", result, 64'h0);
    chk("R9 rst we", 64'(wr_en), 64'h0);
    chk("R9 rst dest", 64'(dest), 64'h0);
    chk("R9 rst ill", 64'(illegal), 64'h0);
    rst = 1'b0;

    // R10 worked example
    vec(32'h00B50533, 64'd5, 64'd7, "R10");
    chk("R10 sum", result, 64'd12);
    chk("R10 dest", 64'(dest), 64'd10);

    // R2 wrap corners
    vec(rt(7'h00, 3'd0, 5'd3, 5'd1, 5'd2), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R2 add wrap");
    vec(rt(7'h20, 3'd0, 5'd3, 5'd1, 5'd2), 64'd0, 64'd1, "R2 sub wrap");
    // R3 high product bits dropped
    vec(rt(7'h01, 3'd0, 5'd4, 5'd1, 5'd2), 64'h8000_0000_0000_0001, 64'd6, "R3 mul");

    // Random data for every supported operation
    for (int k = 0; k < 40; k++) begin
      rnd(a); rnd(b);
      vec(rt(7'h00, 3'd0, 5'd9, 5'd1, 5'd2), a, b, "R2 add");
      vec(rt(7'h20, 3'd0, 5'd9, 5'd1, 5'd2), a, b, "R2 sub");
      vec(rt(7'h01, 3'd0, 5'd9, 5'd1, 5'd2), a, b, "R3 mul");
      vec(rt(7'h00, 3'd7, 5'd9, 5'd1, 5'd2), a, b, "R5 and");
      vec(rt(7'h00, 3'd6, 5'd9, 5'd1, 5'd2), a, b, "R5 or");
      vec(rt(7'h00, 3'd4, 5'd9, 5'd1, 5'd2), a, b, "R5 xor");
      vec(it(b[11:0], 3'd0, 5'd9, 5'd3), a, u, "R6 addi");
    end

    // R4 every shift amount, upper bits of src_b random
    for (int s = 0; s < 64; s++) begin
      rnd(u);
      b = {u[63:6], 6'(s)};
      rnd(a);
      a[63] = s[0];
      vec(rt(7'h00, 3'd1, 5'd5, 5'd1, 5'd2), a, b, "R4 sll");
      vec(rt(7'h00, 3'd5, 5'd5, 5'd1, 5'd2), a, b, "R4 srl");
      vec(rt(7'h20, 3'd5, 5'd5, 5'd1, 5'd2), a, b, "R4 sra");
    end
    vec(rt(7'h20, 3'd5, 5'd5, 5'd1, 5'd2), 64'h8000_0000_0000_0000, 64'd63, "R4 sra fill");
    chk("R4 sra all ones", result, 64'hFFFF_FFFF_FFFF_FFFF);

    // R6 immediate sign extension and src_b ignored
    vec(it(12'hFFF, 3'd0, 5'd6, 5'd1), 64'd0, 64'h5555, "R6 imm -1");
    chk("R6 neg", result, 64'hFFFF_FFFF_FFFF_FFFF);
    vec(it(12'h800, 3'd0, 5'd6, 5'd1), 64'd0, 64'hAAAA, "R6 imm min");
    vec(it(12'h7FF, 3'd0, 5'd6, 5'd1), 64'd1, 64'hFFFF, "R6 imm max");
    chk("R6 max", result, 64'd2048);

    // R7 rd = 0: no write, result still produced
    vec(rt(7'h00, 3'd0, 5'd0, 5'd1, 5'd2), 64'd3, 64'd4, "R7 add x0");
    chk("R7 res", result, 64'd7);
    vec(it(12'd5, 3'd0, 5'd0, 5'd0), 64'd0, 64'd0, "R7 addi x0");

    // R8 exhaustive funct7 x funct3 on the register opcode
    for (int f7 = 0; f7 < 128; f7++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        rnd(a); rnd(b);
        vec(rt(7'(f7), 3'(f3), 5'd11, 5'd12, 5'd13), a, b, "R8 funct");
      end
    end
    // R8 every opcode value, every funct3 on the immediate opcode
    for (int o = 0; o < 128; o++) begin
      rnd(a); rnd(b);
      vec({25'h0_0152_A0 , 7'(o)}, a, b, "R8 opcode");
    end
    for (int f3 = 0; f3 < 8; f3++) begin
      rnd(a); rnd(b);
      vec(it(12'h123, 3'(f3), 5'd8, 5'd2), a, b, "R8 imm funct3");
    end

    // R9 reset mid-run clears outputs
    instr = rt(7'h00, 3'd0, 5'd9, 5'd1, 5'd2); sa = 64'd10; sb = 64'd20;
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid res", result, 64'h0);
    chk("R9 mid we", 64'(wr_en), 64'h0);
    rst = 1'b0;
    vec(rt(7'h00, 3'd0, 5'd9, 5'd1, 5'd2), 64'd10, 64'd20, "R9 after");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule